// File: doc/BRIEF.md
# Transmit Descriptor Write-Back Batcher

This block sits beside a transmit DMA engine and decides when the status of completed transmit descriptors is written back to host memory. Each cycle it may receive one completion strobe with the ring index of the finished descriptor and a report-status flag. The block keeps a contiguous run of pending descriptors. It raises a write-back request with a start index and a count, and holds that request until the memory side returns a burst-done pulse.

A two-bit batch threshold selects the mode. At zero, each report-status descriptor is written back on its own as soon as it finishes. At a non-zero value, and only while both delay-timer settings are non-zero, the block gathers every completed descriptor into a burst until the threshold is met. A run always opens with a report-status descriptor. A flush strobe from the delay timers sends out a partial run at once. A burst never crosses the end of the ring, so a run that wraps is sent as two bursts.

Top module: `wb_burst_ctrl`

## Requirements
- R1: After reset, `wb_req` is 0 and `pend_cnt` is 0.
- R2: In immediate mode (threshold 0), a completion with `cmpl_rs`=1 and no other descriptor held raises `wb_req` on the clock edge that captures it, with `wb_start` = its index and `wb_cnt` = 1. A completion with `cmpl_rs`=0 and no descriptor held leaves `pend_cnt` at 0.
- R3: In batch mode (threshold 1..3 and both delay inputs non-zero), every completion after the run opens is counted whatever its flag. The request rises on the edge where the held count reaches the threshold, and `wb_cnt` equals the held count.
- R4: A run opens only with a report-status completion. Completions with `cmpl_rs`=0 that arrive while nothing is held are dropped in both modes, and `pend_cnt` stays 0.
- R5: With a non-zero threshold and either `pkt_dly` or `abs_dly` equal to 0, the block behaves as in immediate mode.
- R6: In batch mode, a `flush_stb` pulse issues the held descriptors below the threshold on the same edge, or right after the outstanding burst finishes.
- R7: Completions that arrive while a burst is outstanding are added to `pend_cnt`. On the `burst_done` edge, `pend_cnt` drops by `wb_cnt` and `wb_req` falls. The next request comes no earlier than the following edge. In immediate mode, that next request runs through the last report-status descriptor held.
- R8: `wb_start + wb_cnt` never exceeds DEPTH. The part of a run past the ring end goes out as a second burst starting at index 0, without waiting for the threshold.
- R9: While `wb_req` is high and `burst_done` is low, `wb_start` and `wb_cnt` hold their values.
- R10: `pend_cnt` equals the number of descriptors held, including those of the outstanding burst, and never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmpl_vld | input | 1 | Descriptor completion strobe |
| cmpl_rs | input | 1 | Report-status flag of the completed descriptor |
| cmpl_idx | input | IDX_W | Ring index of the completed descriptor |
| wb_thresh | input | THR_W | Batch threshold, 0 selects immediate mode |
| pkt_dly | input | DLY_W | Packet delay timer setting (only zero/non-zero matters) |
| abs_dly | input | DLY_W | Absolute delay timer setting (only zero/non-zero matters) |
| flush_stb | input | 1 | Timer-expiry flush pulse |
| burst_done | input | 1 | Write-back burst finished |
| wb_req | output | 1 | Write-back request |
| wb_start | output | IDX_W | First ring index of the burst |
| wb_cnt | output | CNT_W | Number of descriptors in the burst |
| pend_cnt | output | CNT_W | Descriptors currently held |

## Verification
A completion, flush or threshold change that is driven before an edge shows on `pend_cnt` and, if it triggers one, on `wb_req` right after that same edge. A `burst_done` clears the request on its edge, and any follow-on burst appears one edge later. The bench drives inputs on the falling edge and runs its queue-based model for that input set. It compares every output on the next falling edge, so each expected value lines up with the edge the requirement names.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  typedef enum logic {
    WB_IMMEDIATE = 1'b0,
    WB_BATCH     = 1'b1
  } wb_mode_e;
endpackage

// File: rtl/wbb_mode_sel.sv
module wbb_mode_sel
  import wbb_pkg::*;
#(
  parameter int THR_W = 2,
  parameter int DLY_W = 16
) (
  input  logic [THR_W-1:0] thr,
  input  logic [DLY_W-1:0] pkt_dly,
  input  logic [DLY_W-1:0] abs_dly,
  output wb_mode_e         mode
);
  // Batching needs a non-zero threshold and both delay timers running.
  always_comb begin
    if ((|thr) && (|pkt_dly) && (|abs_dly)) mode = WB_BATCH;
    else                                    mode = WB_IMMEDIATE;
  end
endmodule

// File: rtl/wbb_run_track.sv
module wbb_run_track #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmpl_vld,
  input  logic             cmpl_rs,
  input  logic [IDX_W-1:0] cmpl_idx,
  input  logic             done_acc,
  input  logic [CNT_W-1:0] done_cnt,
  input  logic             drop_ok,
  output logic [IDX_W-1:0] start_nxt,
  output logic [CNT_W-1:0] acc_nxt,
  output logic [CNT_W-1:0] rs_nxt,
  output logic [CNT_W-1:0] acc_q
);
  localparam int SUM_W = CNT_W + 1;

  logic [IDX_W-1:0] start_q;
  logic [CNT_W-1:0] rs_q;
  logic [IDX_W-1:0] start_a;
  logic [CNT_W-1:0] acc_a, rs_a;
  logic [SUM_W-1:0] sum;
  logic             upd_en;

  always_comb begin
    // stage 1: retire the finished burst
    acc_a   = acc_q;
    start_a = start_q;
    rs_a    = rs_q;
    sum     = SUM_W'(start_q) + SUM_W'(done_cnt);
    if (sum >= SUM_W'(DEPTH)) sum = sum - SUM_W'(DEPTH);
    if (done_acc) begin
      acc_a   = acc_q - done_cnt;
      start_a = sum[IDX_W-1:0];
      rs_a    = (rs_q > done_cnt) ? (rs_q - done_cnt) : '0;
    end
    // stage 2: add the new completion
    acc_nxt   = acc_a;
    start_nxt = start_a;
    rs_nxt    = rs_a;
    if (cmpl_vld) begin
      if (acc_a == '0) begin
        if (cmpl_rs) begin
          start_nxt = cmpl_idx;
          acc_nxt   = CNT_W'(1);
          rs_nxt    = CNT_W'(1);
        end
      end else begin
        acc_nxt = acc_a + CNT_W'(1);
        if (cmpl_rs) rs_nxt = acc_a + CNT_W'(1);
      end
    end
    // stage 3: in immediate mode a tail without report status is not kept
    if (drop_ok && (rs_nxt == '0)) acc_nxt = '0;
  end

  assign upd_en = done_acc | cmpl_vld | drop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      acc_q   <= '0;
      rs_q    <= '0;
    end else if (upd_en) begin
      start_q <= start_nxt;
      acc_q   <= acc_nxt;
      rs_q    <= rs_nxt;
    end
  end
endmodule

// File: rtl/wbb_issue.sv
module wbb_issue
  import wbb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5,
  parameter int THR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wb_mode_e         mode,
  input  logic [THR_W-1:0] thr,
  input  logic             flush_stb,
  input  logic             burst_done,
  input  logic [IDX_W-1:0] start_nxt,
  input  logic [CNT_W-1:0] acc_nxt,
  input  logic [CNT_W-1:0] rs_nxt,
  output logic             wb_req,
  output logic [IDX_W-1:0] wb_start,
  output logic [CNT_W-1:0] wb_cnt,
  output logic             done_acc
);
  logic             req_q, req_d;
  logic [IDX_W-1:0] start_q, start_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             force_q, force_d;
  logic             force_eff, clip;
  logic [CNT_W-1:0] seg, want, cut;

  assign done_acc  = req_q & burst_done;
  assign force_eff = force_q | flush_stb;
  assign seg       = CNT_W'(DEPTH) - CNT_W'(start_nxt);

  always_comb begin
    if (mode == WB_BATCH)
      want = (force_eff || (acc_nxt >= CNT_W'(thr))) ? acc_nxt : '0;
    else
      want = rs_nxt;
    clip = (want > seg);
    cut  = clip ? seg : want;
  end

  always_comb begin
    req_d   = req_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    force_d = force_q;
    if (!req_q) begin
      if (want != '0) begin
        req_d   = 1'b1;
        start_d = start_nxt;
        cnt_d   = cut;
        force_d = clip;
      end else begin
        force_d = 1'b0;
      end
    end else begin
      force_d = force_eff;
      if (burst_done) req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      start_q <= '0;
      cnt_q   <= '0;
      force_q <= 1'b0;
    end else begin
      req_q   <= req_d;
      force_q <= force_d;
      if (!req_q) begin
        start_q <= start_d;
        cnt_q   <= cnt_d;
      end
    end
  end

  assign wb_req   = req_q;
  assign wb_start = start_q;
  assign wb_cnt   = cnt_q;
endmodule

// File: rtl/wb_burst_ctrl.sv
module wb_burst_ctrl
  import wbb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int THR_W = 2,
  parameter int DLY_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmpl_vld,
  input  logic             cmpl_rs,
  input  logic [IDX_W-1:0] cmpl_idx,
  input  logic [THR_W-1:0] wb_thresh,
  input  logic [DLY_W-1:0] pkt_dly,
  input  logic [DLY_W-1:0] abs_dly,
  input  logic             flush_stb,
  input  logic             burst_done,
  output logic             wb_req,
  output logic [IDX_W-1:0] wb_start,
  output logic [CNT_W-1:0] wb_cnt,
  output logic [CNT_W-1:0] pend_cnt
);
  logic             rst_meta, rst_sync_n;
  wb_mode_e         mode;
  logic [IDX_W-1:0] start_nxt;
  logic [CNT_W-1:0] acc_nxt, rs_nxt;
  logic             done_acc, drop_ok;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  wbb_mode_sel #(.THR_W(THR_W), .DLY_W(DLY_W)) u_mode (
    .thr(wb_thresh), .pkt_dly(pkt_dly), .abs_dly(abs_dly), .mode(mode)
  );

  assign drop_ok = (mode == WB_IMMEDIATE) && !wb_req;

  wbb_run_track #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_run (
    .clk(clk), .rst_n(rst_sync_n),
    .cmpl_vld(cmpl_vld), .cmpl_rs(cmpl_rs), .cmpl_idx(cmpl_idx),
    .done_acc(done_acc), .done_cnt(wb_cnt), .drop_ok(drop_ok),
    .start_nxt(start_nxt), .acc_nxt(acc_nxt), .rs_nxt(rs_nxt), .acc_q(pend_cnt)
  );

  wbb_issue #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .THR_W(THR_W)) u_iss (
    .clk(clk), .rst_n(rst_sync_n), .mode(mode), .thr(wb_thresh),
    .flush_stb(flush_stb), .burst_done(burst_done),
    .start_nxt(start_nxt), .acc_nxt(acc_nxt), .rs_nxt(rs_nxt),
    .wb_req(wb_req), .wb_start(wb_start), .wb_cnt(wb_cnt), .done_acc(done_acc)
  );
endmodule

// File: rtl/wbb_chk.sv
module wbb_chk #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             burst_done,
  input logic             wb_req,
  input logic [IDX_W-1:0] wb_start,
  input logic [CNT_W-1:0] wb_cnt,
  input logic [CNT_W-1:0] pend_cnt
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !burst_done) |=> (wb_req && $stable(wb_start) && $stable(wb_cnt)));
  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> ((int'(wb_start) + int'(wb_cnt)) <= DEPTH));
  // R7
  gap_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && burst_done) |=> !wb_req);
  // R10
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend_cnt) <= DEPTH);
  // R3
  burst_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> ((wb_cnt != '0) && (wb_cnt <= pend_cnt)));
endmodule

bind wb_burst_ctrl wbb_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .burst_done(burst_done), .wb_req(wb_req),
  .wb_start(wb_start), .wb_cnt(wb_cnt), .pend_cnt(pend_cnt)
);

// File: tb/tb_wb_burst_ctrl.sv
module tb_wb_burst_ctrl;
  localparam int DEPTH = 16;
  localparam int IDX_W = 4;
  localparam int CNT_W = 5;

  logic clk, rst_n;
  logic cmpl_vld, cmpl_rs, flush_stb, burst_done;
  logic [IDX_W-1:0] cmpl_idx;
  logic [1:0] wb_thresh;
  logic [15:0] pkt_dly, abs_dly;
  logic wb_req;
  logic [IDX_W-1:0] wb_start;
  logic [CNT_W-1:0] wb_cnt, pend_cnt;

  wb_burst_ctrl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .cmpl_vld(cmpl_vld), .cmpl_rs(cmpl_rs),
    .cmpl_idx(cmpl_idx), .wb_thresh(wb_thresh), .pkt_dly(pkt_dly),
    .abs_dly(abs_dly), .flush_stb(flush_stb), .burst_done(burst_done),
    .wb_req(wb_req), .wb_start(wb_start), .wb_cnt(wb_cnt), .pend_cnt(pend_cnt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0, bad = 0;
  string tag = "R1";
  int next_idx = 0;
  // reference model state
  int  q_idx[$];
  bit  q_rs[$];
  bit  m_req = 0, m_force = 0;
  int  m_start = 0, m_cnt = 0;
  bit  finished = 0;

  function automatic int rs_span();
    int n = 0;
    for (int i = 0; i < q_idx.size(); i++) if (q_rs[i]) n = i + 1;
    return n;
  endfunction

  function automatic void model_step(bit v, bit r, int idx, bit f, bit d);
    bit busy = m_req;
    bit batch = (wb_thresh != 0) && (pkt_dly != 0) && (abs_dly != 0);
    bit feff = m_force | f;
    int want, seg, cut;
    if (d && busy) for (int i = 0; i < m_cnt; i++) begin
      void'(q_idx.pop_front()); void'(q_rs.pop_front());
    end
    if (v && (q_idx.size() > 0 || r)) begin q_idx.push_back(idx); q_rs.push_back(r); end
    if (!batch && !busy && rs_span() == 0) begin q_idx.delete(); q_rs.delete(); end
    if (batch) want = (feff || q_idx.size() >= int'(wb_thresh)) ? q_idx.size() : 0;
    else       want = rs_span();
    seg = (q_idx.size() > 0) ? DEPTH - q_idx[0] : DEPTH;
    cut = (want > seg) ? seg : want;
    if (!busy) begin
      if (want != 0) begin
        m_req = 1; m_start = q_idx[0]; m_cnt = cut; m_force = (want > seg);
      end else m_force = 0;
    end else begin
      m_force = feff;
      if (d) m_req = 0;
    end
  endfunction

  task automatic fail_line(string what, int act, int exp);
    bad++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  task automatic check_all();
    total++;
    if (wb_req !== m_req) fail_line("wb_req", int'(wb_req), int'(m_req));
    if (m_req) begin
      total++;
      if (int'(wb_start) != m_start) fail_line("wb_start", int'(wb_start), m_start);
      total++;
      if (int'(wb_cnt) != m_cnt) fail_line("wb_cnt", int'(wb_cnt), m_cnt);
    end
    total++;
    if (int'(pend_cnt) != q_idx.size())
      fail_line("pend_cnt (R10)", int'(pend_cnt), q_idx.size());
  endtask

  // drive one cycle at the falling edge, predict, check at next falling edge
  task automatic cyc(bit v, bit r, bit f, bit d);
    cmpl_vld = v; cmpl_rs = r; flush_stb = f; burst_done = d;
    cmpl_idx = IDX_W'(next_idx);
    model_step(v, r, next_idx, f, d);
    if (v) next_idx = (next_idx + 1) % DEPTH;
    @(negedge clk);
    check_all();
  endtask

  task automatic cfg(int thr, int pk, int ab);
    wb_thresh = 2'(thr); pkt_dly = 16'(pk); abs_dly = 16'(ab);
  endtask

  task automatic drain();
    for (int i = 0; i < 40; i++) begin
      if (!m_req && q_idx.size() == 0) break;
      cyc(0, 0, 1, m_req);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    cmpl_vld = 0; cmpl_rs = 0; flush_stb = 0; burst_done = 0; cmpl_idx = '0;
    cfg(0, 5, 5);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    tag = "R1"; check_all();

    tag = "R2";                    // immediate: single-descriptor bursts
    cyc(1, 0, 0, 0); cyc(1, 1, 0, 0); cyc(0, 0, 0, 1); cyc(1, 1, 0, 0); cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);

    tag = "R4";                    // run opens only with report status
    cfg(2, 5, 5);
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 1, 0, 0);
    tag = "R3";
    cyc(1, 0, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 1); cyc(0, 0, 0, 0);
    cfg(3, 5, 5);
    cyc(1, 1, 0, 0); cyc(1, 1, 0, 0); cyc(1, 0, 0, 0); cyc(0, 0, 0, 1);

    tag = "R5";                    // a zero timer falls back to immediate
    cfg(3, 0, 5);
    cyc(1, 1, 0, 0); cyc(0, 0, 0, 1);
    cfg(3, 5, 0);
    cyc(1, 0, 0, 0); cyc(1, 1, 0, 0); cyc(0, 0, 0, 1); cyc(0, 0, 0, 0);

    tag = "R6";                    // flush of a partial batch
    cfg(3, 5, 5);
    cyc(1, 1, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 1, 0); cyc(0, 0, 0, 1); cyc(0, 0, 0, 0);

    tag = "R7";                    // completions during an outstanding burst
    cfg(0, 5, 5);
    cyc(1, 1, 0, 0); cyc(1, 1, 0, 0); cyc(1, 0, 0, 0); cyc(1, 1, 0, 0);
    cyc(0, 0, 0, 1); cyc(0, 0, 0, 0); cyc(0, 0, 0, 1); cyc(0, 0, 0, 0);

    tag = "R8";                    // run across the ring end is split
    drain();
    next_idx = DEPTH - 2;
    cfg(3, 5, 5);
    cyc(1, 1, 0, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 1); cyc(0, 0, 0, 0); cyc(0, 0, 0, 1); cyc(0, 0, 0, 0);

    tag = "R9";                    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      bit v, r, f, d;
      if (n % 250 == 0)
        cfg($urandom % 4, ($urandom % 4 == 0) ? 0 : 7, ($urandom % 4 == 0) ? 0 : 9);
      v = ($urandom % 3 != 0) && (q_idx.size() < DEPTH - 2);
      r = ($urandom % 3 == 0);
      f = ($urandom % 20 == 0);
      d = m_req && ($urandom % 3 == 0);
      cyc(v, r, f, d);
    end
    drain();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule